// File: doc/BRIEF.md
# Event-Queue MSI Interrupt Controller

This block receives inbound posted message-signalled interrupt writes and records each one as an event word. Each write lands in an address window. The block finds the target group from the write address, up to six groups in all. It then writes the low six data bits as a 32-bit entry into that group's 64-entry circular queue in system memory. The queue write goes out on a valid/ready memory write port. When the write completes, the block advances the group's tail pointer, which only hardware moves.

Software services a group as follows. It reads the tail through a 32-bit register interface, consumes entries from its head up to the tail, and writes the new head back. Each group drives its own level interrupt line, which stays high while the queue holds unconsumed events and the group's enables are set. One inbound write is in flight at a time, and `msi_ready_o` stalls the source while the queue write is outstanding.

The block has two memory layouts, chosen by the parameter `PER_REGION`:
- **Shared (0):** one 4 KiB queue page and a packed set of 32-bit MSI targets.
- **Per-region (1):** each group has its own 4 KiB page for its queue and its own 4 KiB window for its MSI target.

Top module: `msi_eq_ctrl`

## Requirements
- R1: In shared mode, an inbound write to MSI page base + 4n targets group n (n < NUM_Q), and each group drives its own bit of `irq_o`.
- R2: Head and tail pointers are 6 bits wide and wrap modulo 64. The tail advances from 63 to 0.
- R3: A queue entry holds the low 6 bits of the inbound data in bits 5:0, with bits 31:6 zero.
- R4: Each accepted event advances the tail by exactly one. The tail is read at 0x254+8n and ignores writes. The head is written and read at 0x250+8n, takes data bits 5:0, and hardware never changes it.
- R5: The tail changes only after the queue-entry write has completed its valid/ready handshake. While `mem_ready_i` is low, the request address and data are held stable and `msi_ready_o` stays low.
- R6: In shared mode, the entry for group n goes to queue page base + n*256 + tail*4. The queue page is at 0x200 (low half) and 0x2C0 (high half), and the MSI page is at 0x204 (low half) and 0x2C4 (high half).
- R7: When advancing the tail would make it equal to the head, the write is dropped and bit 16 of the group's control register is set. That bit stays set until software writes 1 to it. Writing 0 to it leaves it set.
- R8: Group n's control register sits at 0x210+4n, with bit 11 as interrupt enable, bit 1 as interrupt-on-event and bit 0 as queue enable. `irq_o[n]` is high only when tail != head, all three bits are set, and bit n of the mask register at 0x208 is set.
- R9: The interrupt line follows a head write one cycle after the head register updates. It drops when the head reaches the tail and stays high while events remain.
- R10: Reset clears all pointers, control bits, enables, the mask and the page registers. All interrupts are low and no memory write is pending.
- R11: No memory write is made and no tail moves for an inbound write that targets a group whose queue enable is clear, falls outside the group range, is misaligned, or lies below the MSI page.
- R12: In per-region mode, group n's MSI target is MSI page base + n*4096, and its entries go to queue page base + n*4096 + tail*4. Any other offset in the window is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| msi_valid_i | input | 1 | Inbound MSI write valid |
| msi_ready_o | output | 1 | Block can take an inbound write |
| msi_addr_i | input | 64 | Inbound MSI write address |
| msi_data_i | input | 32 | Inbound MSI write data |
| mem_valid_o | output | 1 | Queue-entry write request valid |
| mem_ready_i | input | 1 | Memory accepts the queue-entry write |
| mem_addr_o | output | 64 | Queue-entry byte address |
| mem_data_o | output | 32 | Queue-entry word |
| irq_o | output | NUM_Q | Per-group interrupt level |

## Verification
The hardest state to reach from the ports is a full queue with its sticky overflow bit set after the tail has wrapped. To reach it, the bench first leaves group 0's head and tail at a nonzero slot. It then sends 64 back-to-back events without consuming any, which makes the tail pass 63 and stop one slot behind the head. The 64th event must then be dropped and flagged. A second hard case is a memory write held off by a low ready, which leaves the tail frozen mid-flight. The bench forces it by holding `mem_ready_i` low for several cycles and reading the tail register during the stall.

// File: rtl/msi_eq_pkg.sv
package msi_eq_pkg;
  localparam int unsigned ADDR_W  = 64;
  localparam int unsigned DW      = 32;
  localparam int unsigned REG_AW  = 12;
  localparam int unsigned PTR_W   = 6;
  localparam int unsigned DEPTH   = 1 << PTR_W;
  localparam int unsigned EVT_W   = 6;
  localparam int unsigned PAGE_SH = 12;

  localparam logic [REG_AW-1:0] OFF_EQ_LO = 12'h200;
  localparam logic [REG_AW-1:0] OFF_EQ_HI = 12'h2C0;
  localparam logic [REG_AW-1:0] OFF_MW_LO = 12'h204;
  localparam logic [REG_AW-1:0] OFF_MW_HI = 12'h2C4;
  localparam logic [REG_AW-1:0] OFF_MASK  = 12'h208;
  localparam logic [REG_AW-1:0] OFF_CTRL  = 12'h210;
  localparam logic [REG_AW-1:0] OFF_HEAD  = 12'h250;
  localparam logic [REG_AW-1:0] OFF_TAIL  = 12'h254;

  localparam int unsigned CB_Q_EN   = 0;
  localparam int unsigned CB_EVT    = 1;
  localparam int unsigned CB_IRQ_EN = 11;
  localparam int unsigned CB_OVF    = 16;
endpackage

// File: rtl/msi_eq_decode.sv
module msi_eq_decode
  import msi_eq_pkg::*;
#(
  parameter int unsigned NUM_Q      = 6,
  parameter bit          PER_REGION = 1'b0,
  parameter int unsigned GRP_W      = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              hit_o,
  output logic [GRP_W-1:0]  grp_o
);
  localparam int unsigned SH = PER_REGION ? PAGE_SH : 2;

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] idx;

  always_comb begin
    off   = addr_i - base_i;
    idx   = off >> SH;
    hit_o = (addr_i >= base_i) && (off[SH-1:0] == '0) && (idx < ADDR_W'(NUM_Q));
    grp_o = idx[GRP_W-1:0];
  end
endmodule

// File: rtl/msi_eq_queue.sv
module msi_eq_queue
  import msi_eq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             irq_en_d_i,
  input  logic             evt_d_i,
  input  logic             qen_d_i,
  input  logic             ovf_clr_i,
  input  logic             head_we_i,
  input  logic [PTR_W-1:0] head_d_i,
  input  logic             mask_i,
  input  logic             ovf_set_i,
  input  logic             push_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic [DW-1:0]    ctrl_o,
  output logic             en_o,
  output logic             full_o,
  output logic             irq_o
);
  logic [PTR_W-1:0] head_q, tail_q, pend;
  logic irq_en_q, evt_q, qen_q, ovf_q, irq_q;

  assign pend = tail_q - head_q;   // modulo-64 distance

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q   <= '0;
      tail_q   <= '0;
      irq_en_q <= 1'b0;
      evt_q    <= 1'b0;
      qen_q    <= 1'b0;
      ovf_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (ctrl_we_i) begin
        irq_en_q <= irq_en_d_i;
        evt_q    <= evt_d_i;
        qen_q    <= qen_d_i;
      end
      if (ovf_set_i) ovf_q <= 1'b1;
      else if (ctrl_we_i && ovf_clr_i) ovf_q <= 1'b0;
      if (head_we_i) head_q <= head_d_i;
      if (push_i) tail_q <= tail_q + PTR_W'(1);
      irq_q <= (pend != '0) && irq_en_q && evt_q && qen_q && mask_i;
    end
  end

  always_comb begin
    ctrl_o            = '0;
    ctrl_o[CB_Q_EN]   = qen_q;
    ctrl_o[CB_EVT]    = evt_q;
    ctrl_o[CB_IRQ_EN] = irq_en_q;
    ctrl_o[CB_OVF]    = ovf_q;
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
  assign en_o   = qen_q;
  assign full_o = (tail_q + PTR_W'(1)) == head_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/msi_eq_writer.sv
module msi_eq_writer
  import msi_eq_pkg::*;
#(
  parameter int unsigned GRP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_d_i,
  input  logic [EVT_W-1:0]  evt_d_i,
  input  logic [GRP_W-1:0]  grp_d_i,
  input  logic              mem_ready_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [GRP_W-1:0]  done_grp_o,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_data_o
);
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  logic [EVT_W-1:0]  evt_q;
  logic [GRP_W-1:0]  grp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      evt_q   <= '0;
      grp_q   <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      addr_q  <= addr_d_i;
      evt_q   <= evt_d_i;
      grp_q   <= grp_d_i;
    end else if (done_o) begin
      valid_q <= 1'b0;
    end
  end

  assign done_o      = valid_q && mem_ready_i;
  assign busy_o      = valid_q;
  assign done_grp_o  = grp_q;
  assign mem_valid_o = valid_q;
  assign mem_addr_o  = addr_q;
  assign mem_data_o  = {{(DW-EVT_W){1'b0}}, evt_q};
endmodule

// File: rtl/msi_eq_ctrl.sv
module msi_eq_ctrl
  import msi_eq_pkg::*;
#(
  parameter int unsigned NUM_Q      = 6,
  parameter bit          PER_REGION = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic              msi_valid_i,
  output logic              msi_ready_o,
  input  logic [ADDR_W-1:0] msi_addr_i,
  input  logic [DW-1:0]     msi_data_i,
  output logic              mem_valid_o,
  input  logic              mem_ready_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DW-1:0]     mem_data_o,
  output logic [NUM_Q-1:0]  irq_o
);
  localparam int unsigned GRP_W = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam int unsigned Q_SH  = PER_REGION ? PAGE_SH : $clog2(DEPTH * 4);

  logic [DW-1:0]    eq_lo_q, eq_hi_q, mw_lo_q, mw_hi_q;
  logic [NUM_Q-1:0] mask_q;

  logic [PTR_W-1:0] head [NUM_Q];
  logic [PTR_W-1:0] tail [NUM_Q];
  logic [DW-1:0]    ctrl [NUM_Q];
  logic [NUM_Q-1:0] q_en, q_full;
  logic [NUM_Q*PTR_W-1:0] tail_all;

  logic             hit, busy, done, fire, accept, ovf_hit;
  logic [GRP_W-1:0] grp, done_grp;
  logic             sel_en, sel_full;
  logic [PTR_W-1:0] sel_tail;
  logic [ADDR_W-1:0] mw_base, eq_base, entry_addr;
  logic             unused_data;

  assign unused_data = ^msi_data_i[DW-1:EVT_W];
  assign mw_base = {mw_hi_q, mw_lo_q};
  assign eq_base = {eq_hi_q, eq_lo_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eq_lo_q <= '0;
      eq_hi_q <= '0;
      mw_lo_q <= '0;
      mw_hi_q <= '0;
      mask_q  <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        OFF_EQ_LO: eq_lo_q <= reg_wdata_i;
        OFF_EQ_HI: eq_hi_q <= reg_wdata_i;
        OFF_MW_LO: mw_lo_q <= reg_wdata_i;
        OFF_MW_HI: mw_hi_q <= reg_wdata_i;
        OFF_MASK:  mask_q  <= reg_wdata_i[NUM_Q-1:0];
        default: ;
      endcase
    end
  end

  msi_eq_decode #(
    .NUM_Q     (NUM_Q),
    .PER_REGION(PER_REGION),
    .GRP_W     (GRP_W)
  ) decode_i (
    .addr_i(msi_addr_i),
    .base_i(mw_base),
    .hit_o (hit),
    .grp_o (grp)
  );

  always_comb begin
    sel_en   = 1'b0;
    sel_full = 1'b0;
    sel_tail = '0;
    for (int i = 0; i < NUM_Q; i++) begin
      if (grp == GRP_W'(i)) begin
        sel_en   = q_en[i];
        sel_full = q_full[i];
        sel_tail = tail[i];
      end
    end
  end

  assign msi_ready_o = !busy;
  assign fire        = msi_valid_i && !busy;
  assign accept      = fire && hit && sel_en && !sel_full;
  assign ovf_hit     = fire && hit && sel_en && sel_full;
  assign entry_addr  = eq_base + (ADDR_W'(grp) << Q_SH) + (ADDR_W'(sel_tail) << 2);

  msi_eq_writer #(
    .GRP_W(GRP_W)
  ) writer_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .addr_d_i   (entry_addr),
    .evt_d_i    (msi_data_i[EVT_W-1:0]),
    .grp_d_i    (grp),
    .mem_ready_i(mem_ready_i),
    .busy_o     (busy),
    .done_o     (done),
    .done_grp_o (done_grp),
    .mem_valid_o(mem_valid_o),
    .mem_addr_o (mem_addr_o),
    .mem_data_o (mem_data_o)
  );

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic ctrl_we, head_we;
    assign ctrl_we = reg_we_i && (reg_addr_i == REG_AW'(OFF_CTRL + 4 * g));
    assign head_we = reg_we_i && (reg_addr_i == REG_AW'(OFF_HEAD + 8 * g));

    msi_eq_queue queue_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_we_i (ctrl_we),
      .irq_en_d_i(reg_wdata_i[CB_IRQ_EN]),
      .evt_d_i   (reg_wdata_i[CB_EVT]),
      .qen_d_i   (reg_wdata_i[CB_Q_EN]),
      .ovf_clr_i (reg_wdata_i[CB_OVF]),
      .head_we_i (head_we),
      .head_d_i  (reg_wdata_i[PTR_W-1:0]),
      .mask_i    (mask_q[g]),
      .ovf_set_i (ovf_hit && (grp == GRP_W'(g))),
      .push_i    (done && (done_grp == GRP_W'(g))),
      .head_o    (head[g]),
      .tail_o    (tail[g]),
      .ctrl_o    (ctrl[g]),
      .en_o      (q_en[g]),
      .full_o    (q_full[g]),
      .irq_o     (irq_o[g])
    );

    assign tail_all[g*PTR_W +: PTR_W] = tail[g];
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      OFF_EQ_LO: reg_rdata_o = eq_lo_q;
      OFF_EQ_HI: reg_rdata_o = eq_hi_q;
      OFF_MW_LO: reg_rdata_o = mw_lo_q;
      OFF_MW_HI: reg_rdata_o = mw_hi_q;
      OFF_MASK:  reg_rdata_o[NUM_Q-1:0] = mask_q;
      default: ;
    endcase
    for (int i = 0; i < NUM_Q; i++) begin
      if (reg_addr_i == REG_AW'(OFF_CTRL + 4 * i)) reg_rdata_o = ctrl[i];
      if (reg_addr_i == REG_AW'(OFF_HEAD + 8 * i)) reg_rdata_o = DW'(head[i]);
      if (reg_addr_i == REG_AW'(OFF_TAIL + 8 * i)) reg_rdata_o = DW'(tail[i]);
    end
  end
endmodule

// File: rtl/msi_eq_ctrl_chk.sv
module msi_eq_ctrl_chk
  import msi_eq_pkg::*;
#(
  parameter int unsigned NUM_Q = 6
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   mem_valid_o,
  input logic                   mem_ready_i,
  input logic [ADDR_W-1:0]      mem_addr_o,
  input logic [DW-1:0]          mem_data_o,
  input logic [NUM_Q-1:0]       irq_o,
  input logic [NUM_Q*PTR_W-1:0] tail_all,
  input logic [NUM_Q-1:0]       mask_q
);
  // R5: stalled request holds address and data
  a_r5_hold_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o));

  // R5: tails move only on a completed memory handshake
  a_r5_tail_after_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_valid_o && mem_ready_i) |=> $stable(tail_all));

  // R3: only six event bits reach memory
  a_r3_event_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> mem_data_o[DW-1:EVT_W] == '0);

  // R8: a masked group never interrupts
  a_r8_mask_gates_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~$past(mask_q)) == '0);
endmodule

bind msi_eq_ctrl msi_eq_ctrl_chk #(.NUM_Q(NUM_Q)) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mem_valid_o(mem_valid_o),
  .mem_ready_i(mem_ready_i),
  .mem_addr_o (mem_addr_o),
  .mem_data_o (mem_data_o),
  .irq_o      (irq_o),
  .tail_all   (tail_all),
  .mask_q     (mask_q)
);

// File: tb/msi_eq_ctrl_tb_top.sv
module msi_eq_ctrl_tb_top;
  import msi_eq_pkg::*;

  localparam int NQ = 6;
  localparam logic [63:0] EQB = 64'h0000_0001_8000_0000;
  localparam logic [63:0] MWB = 64'h0000_0002_FEE0_0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic we_s, we_p;
  logic [11:0] raddr;
  logic [31:0] wdata, rdata_s, rdata_p;
  logic msi_v, rdy_s, rdy_p;
  logic [63:0] msi_a;
  logic [31:0] msi_d;
  logic mem_rdy, mv_s, mv_p;
  logic [63:0] ma_s, ma_p;
  logic [31:0] md_s, md_p;
  logic [NQ-1:0] irq_s, irq_p;

  int n_chk = 0, n_bad = 0, wcnt_s = 0, wcnt_p = 0;
  logic [31:0] mem_s   [NQ*64];
  logic [31:0] exp_mem [NQ*64];
  logic [5:0]  exp_tail[NQ];
  logic [5:0]  exp_head[NQ];
  logic [NQ-1:0] exp_en;
  logic [63:0] cap_off, last_a_p;
  logic [31:0] last_d_p;

  msi_eq_ctrl #(.NUM_Q(NQ), .PER_REGION(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we_s), .reg_addr_i(raddr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_s), .msi_valid_i(msi_v), .msi_ready_o(rdy_s), .msi_addr_i(msi_a),
    .msi_data_i(msi_d), .mem_valid_o(mv_s), .mem_ready_i(mem_rdy), .mem_addr_o(ma_s),
    .mem_data_o(md_s), .irq_o(irq_s));

  msi_eq_ctrl #(.NUM_Q(NQ), .PER_REGION(1'b1)) dut_pr_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we_p), .reg_addr_i(raddr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata_p), .msi_valid_i(msi_v), .msi_ready_o(rdy_p), .msi_addr_i(msi_a),
    .msi_data_i(msi_d), .mem_valid_o(mv_p), .mem_ready_i(mem_rdy), .mem_addr_o(ma_p),
    .mem_data_o(md_p), .irq_o(irq_p));

  always @(posedge clk) begin
    if (mv_s && mem_rdy) begin
      wcnt_s++;
      cap_off = ma_s - EQB;
      if (cap_off < 64'(NQ * 256)) mem_s[cap_off[10:2]] = md_s;
    end
    if (mv_p && mem_rdy) begin
      wcnt_p++;
      last_a_p = ma_p;
      last_d_p = md_p;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input bit pr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    raddr = a; wdata = d;
    if (pr) we_p = 1'b1; else we_s = 1'b1;
    @(negedge clk);
    we_p = 1'b0; we_s = 1'b0;
  endtask

  task automatic rd(input bit pr, input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    raddr = a;
    #1 v = pr ? rdata_p : rdata_s;
  endtask

  task automatic wait_idle();
    while (!(rdy_s && rdy_p)) @(negedge clk);
  endtask

  task automatic issue(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk);
    wait_idle();
    msi_v = 1'b1; msi_a = a; msi_d = d;
    @(negedge clk);
    msi_v = 1'b0;
  endtask

  task automatic send(input logic [63:0] a, input logic [31:0] d);
    issue(a, d);
    @(negedge clk);
    wait_idle();
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  // reference queue model for shared mode
  task automatic model_push(input int g, input logic [31:0] d);
    if (exp_en[g] && (exp_tail[g] + 6'd1 != exp_head[g])) begin
      exp_mem[g*64 + int'(exp_tail[g])] = {26'b0, d[5:0]};
      exp_tail[g] = exp_tail[g] + 6'd1;
    end
  endtask

  task automatic mem_compare(input string req);
    for (int w = 0; w < NQ*64; w++) chk(req, 64'(mem_s[w]), 64'(exp_mem[w]));
  endtask

  logic [31:0] v;
  int snap;
  logic [5:0] t3;

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int w = 0; w < NQ*64; w++) begin mem_s[w] = '0; exp_mem[w] = '0; end
    for (int g = 0; g < NQ; g++) begin exp_tail[g] = '0; exp_head[g] = '0; end
    exp_en = '0;
    rst_n = 1'b0; we_s = 0; we_p = 0; raddr = '0; wdata = '0;
    msi_v = 0; msi_a = '0; msi_d = '0; mem_rdy = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk("R10 irq", 64'(irq_s), 0);
    chk("R10 ready", 64'(rdy_s), 1);
    chk("R10 memvalid", 64'(mv_s), 0);
    rd(0, OFF_EQ_LO, v); chk("R10 eqlo", 64'(v), 0);
    rd(0, OFF_EQ_HI, v); chk("R10 eqhi", 64'(v), 0);
    rd(0, OFF_MW_LO, v); chk("R10 mwlo", 64'(v), 0);
    rd(0, OFF_MW_HI, v); chk("R10 mwhi", 64'(v), 0);
    rd(0, OFF_MASK, v);  chk("R10 mask", 64'(v), 0);
    for (int g = 0; g < NQ; g++) begin
      rd(0, 12'(OFF_CTRL + 4*g), v); chk("R10 ctrl", 64'(v), 0);
      rd(0, 12'(OFF_HEAD + 8*g), v); chk("R10 head", 64'(v), 0);
      rd(0, 12'(OFF_TAIL + 8*g), v); chk("R10 tail", 64'(v), 0);
    end

    // configure shared-mode instance
    wr(0, OFF_EQ_LO, EQB[31:0]); wr(0, OFF_EQ_HI, EQB[63:32]);
    wr(0, OFF_MW_LO, MWB[31:0]); wr(0, OFF_MW_HI, MWB[63:32]);
    wr(0, OFF_MASK, 32'h3F);
    for (int g = 0; g < NQ; g++) wr(0, 12'(OFF_CTRL + 4*g), 32'h803);
    exp_en = '1;
    rd(0, OFF_EQ_HI, v); chk("R6 eqhi readback", 64'(v), 64'(EQB[63:32]));
    rd(0, 12'(OFF_CTRL + 4*3), v); chk("R8 ctrl readback", 64'(v), 64'h803);

    // R1 R3 R6 sweep over all groups
    for (int g = 0; g < NQ; g++)
      for (int i = 0; i < 3 + g; i++) begin
        logic [31:0] d;
        d = 32'h9E37_79B9 * 32'(g*8 + i + 1);
        model_push(g, d);
        send(MWB + 64'(4*g), d);
      end
    chk("R1 write count", 64'(wcnt_s), 33);
    for (int g = 0; g < NQ; g++) begin
      rd(0, 12'(OFF_TAIL + 8*g), v); chk("R4 tail", 64'(v), 64'(exp_tail[g]));
    end
    settle();
    chk("R1 irq lines", 64'(irq_s), 64'h3F);
    mem_compare("R3 R6 entries");

    // R9 head writes: partial then full catch-up
    for (int g = 0; g < NQ; g++) begin
      wr(0, 12'(OFF_HEAD + 8*g), 32'hFFFF_FFC0 | 32'(exp_tail[g] - 6'd1));
      settle();
      chk("R9 irq stays with pending", 64'(irq_s[g]), 1);
      rd(0, 12'(OFF_HEAD + 8*g), v); chk("R4 head readback", 64'(v), 64'(exp_tail[g] - 6'd1));
      wr(0, 12'(OFF_HEAD + 8*g), 32'(exp_tail[g]));
      chk("R9 irq one cycle later", 64'(irq_s[g]), 1);
      @(negedge clk);
      chk("R9 irq drops", 64'(irq_s[g]), 0);
      exp_head[g] = exp_tail[g];
    end
    wr(0, 12'(OFF_TAIL + 8*4), 32'h3F);
    rd(0, 12'(OFF_TAIL + 8*4), v); chk("R4 tail ignores write", 64'(v), 64'(exp_tail[4]));

    // R8 enable gating on group 1
    model_push(1, 32'h55); send(MWB + 4, 32'h55); settle();
    chk("R8 irq on", 64'(irq_s[1]), 1);
    wr(0, 12'(OFF_CTRL + 4), 32'h003); settle(); chk("R8 bit11 off", 64'(irq_s[1]), 0);
    wr(0, 12'(OFF_CTRL + 4), 32'h801); settle(); chk("R8 bit1 off", 64'(irq_s[1]), 0);
    wr(0, 12'(OFF_CTRL + 4), 32'h802); settle(); chk("R8 bit0 off", 64'(irq_s[1]), 0);
    wr(0, 12'(OFF_CTRL + 4), 32'h803); settle(); chk("R8 all on", 64'(irq_s[1]), 1);
    wr(0, OFF_MASK, 32'h3D); settle(); chk("R8 mask off", 64'(irq_s[1]), 0);
    wr(0, OFF_MASK, 32'h3F); settle(); chk("R8 mask on", 64'(irq_s[1]), 1);
    wr(0, 12'(OFF_HEAD + 8), 32'(exp_tail[1])); exp_head[1] = exp_tail[1];

    // R11 discarded writes
    snap = wcnt_s;
    wr(0, 12'(OFF_CTRL + 8), 32'h802); exp_en[2] = 1'b0;
    send(MWB + 8, 32'h7);
    send(MWB + 24, 32'h1);
    send(MWB + 2, 32'h1);
    send(MWB - 4, 32'h1);
    chk("R11 no memory write", 64'(wcnt_s), 64'(snap));
    for (int g = 0; g < NQ; g++) begin
      rd(0, 12'(OFF_TAIL + 8*g), v); chk("R11 tail unchanged", 64'(v), 64'(exp_tail[g]));
    end
    settle();
    chk("R11 no irq", 64'(irq_s), 0);
    wr(0, 12'(OFF_CTRL + 8), 32'h803); exp_en[2] = 1'b1;

    // R7 R2 fill group 0 past the wrap until full
    snap = wcnt_s;
    for (int k = 0; k < 64; k++) begin
      logic [31:0] d;
      d = 32'h1000_0000 + 32'(k*3);
      model_push(0, d);
      send(MWB, d);
    end
    chk("R2 tail wrapped", 64'(exp_tail[0]), 2);
    rd(0, OFF_TAIL, v); chk("R2 tail after wrap", 64'(v), 2);
    chk("R7 63 accepted", 64'(wcnt_s - snap), 63);
    rd(0, OFF_CTRL, v); chk("R7 overflow set", 64'(v), 64'h10803);
    wr(0, OFF_CTRL, 32'h803);
    rd(0, OFF_CTRL, v); chk("R7 write zero keeps", 64'(v), 64'h10803);
    wr(0, OFF_CTRL, 32'h10803);
    rd(0, OFF_CTRL, v); chk("R7 write one clears", 64'(v), 64'h803);
    settle();
    chk("R8 full queue irq", 64'(irq_s[0]), 1);
    mem_compare("R2 R3 wrapped entries");
    wr(0, OFF_HEAD, 32'(exp_tail[0])); exp_head[0] = exp_tail[0];

    // R5 backpressure on group 3
    t3 = exp_tail[3];
    mem_rdy = 1'b0;
    issue(MWB + 12, 32'hABCD_012A);
    for (int c = 0; c < 4; c++) begin
      chk("R5 valid held", 64'(mv_s), 1);
      chk("R5 source stalled", 64'(rdy_s), 0);
      chk("R6 entry address", ma_s, EQB + 64'(3*256) + 64'({t3, 2'b00}));
      rd(0, 12'(OFF_TAIL + 24), v); chk("R5 tail frozen", 64'(v), 64'(t3));
    end
    mem_rdy = 1'b1;
    model_push(3, 32'hABCD_012A);
    rd(0, 12'(OFF_TAIL + 24), v); chk("R5 tail after handshake", 64'(v), 64'(t3 + 6'd1));
    chk("R5 request retired", 64'(mv_s), 0);
    chk("R3 stalled entry", 64'(mem_s[3*64 + int'(t3)]), 64'h2A);

    // R12 per-region instance
    wr(1, OFF_EQ_LO, EQB[31:0]); wr(1, OFF_EQ_HI, EQB[63:32]);
    wr(1, OFF_MW_LO, MWB[31:0]); wr(1, OFF_MW_HI, MWB[63:32]);
    wr(1, OFF_MASK, 32'h3F);
    wr(1, 12'(OFF_CTRL + 4), 32'h803);
    wr(1, 12'(OFF_CTRL + 20), 32'h803);
    snap = wcnt_s;
    send(MWB + 64'h1000, 32'hFFFF_FF81);
    chk("R12 group1 address", last_a_p, EQB + 64'h1000);
    chk("R12 group1 data", 64'(last_d_p), 64'h01);
    send(MWB + 64'h5000, 32'h3E);
    chk("R12 group5 address", last_a_p, EQB + 64'h5000);
    send(MWB + 64'h1004, 32'h9);
    chk("R12 offset discarded", 64'(wcnt_p), 2);
    send(MWB + 64'h1000, 32'h5);
    chk("R12 second slot", last_a_p, EQB + 64'h1004);
    rd(1, 12'(OFF_TAIL + 8), v); chk("R12 tail", 64'(v), 2);
    chk("R11 shared ignores pages", 64'(wcnt_s), 64'(snap));
    settle();
    chk("R12 irq lines", 64'(irq_p), 64'h22);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule